// File: doc/BRIEF.md
# Quadrature Encoder Tuning Controller

This block turns the pulses of a rotary quadrature shaft encoder and a handful of front-panel controls into the target frequency, in hertz, of a synthesized oscillator. The two encoder channels are synchronized and decoded into single up or down steps. The operating mode decides which register a step moves and by how much: the main frequency, a receive-offset (clarifier) value, or a calibration trim.

The composed output adds several terms to the main frequency: the clarifier value when it is enabled, the calibration trim, and two fixed offsets, each with its own enable and sign. A band code loads a computed starting frequency. A bank of channel slots stores and restores the main frequency together with the clarifier value. A one-cycle strobe tells a downstream tuning-word serializer that the composed frequency has changed.

Top module: `vfo_tune_ctrl`

## Requirements
- R1: While and after reset, with offsets and clarifier disabled, `freqOut` and `dispFreq` equal BAND_BASE, `ritOut` is 0 and `changeStb` is 0.
- R2: Channel A leading B is the forward direction, following AB = 00→10→11→01→00. Each forward transition is one up step and each reverse transition is one down step. In mode 0 (main) a step moves `dispFreq` by ±10 Hz. In mode 3 (hold) steps are ignored.
- R3: An encoder change in which both channels flip at once is ignored, and no register moves.
- R4: The main frequency saturates at F_MIN and F_MAX and never wraps.
- R5: In mode 1 (clarifier) a step moves `ritOut` by ±10 Hz, clamped to ±10000, and `dispFreq` does not move. The clarifier value enters `freqOut` only while `ritEn` is 1.
- R6: In mode 2 (calibration) a step moves a trim term in `freqOut` by ±1 Hz, clamped to ±CAL_LIM, while `dispFreq` stays frozen.
- R7: Offset k (k = 0 adds OFF0_HZ, k = 1 adds OFF1_HZ) adds its value to `freqOut` when `offEn[k]` is 1. It adds the value when `offNeg[k]` is 0 and subtracts it when `offNeg[k]` is 1.
- R8: A `bandLoad` pulse sets the main frequency to BAND_BASE + `bandCode`·BAND_STEP, clamped to the F_MIN..F_MAX range.
- R9: A `savePulse` stores the main frequency and the clarifier value in slot `chanSel`, one of NUM_CH = 16 slots. A `recallPulse` restores both values. A recall takes priority over a band load and a step in the same cycle.
- R10: `freqOut` = main + (`ritEn` ? clarifier : 0) + trim + the enabled offsets, in 32-bit two's complement. `changeStb` is high for exactly one cycle each time `freqOut` changes, and stays low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| encA | input | 1 | Encoder channel A (asynchronous) |
| encB | input | 1 | Encoder channel B (asynchronous) |
| modeSel | input | 2 | 0 main, 1 clarifier, 2 calibration, 3 hold |
| ritEn | input | 1 | Include the clarifier value in the output |
| offEn | input | 2 | Enables for the two fixed offsets |
| offNeg | input | 2 | Sign of each offset (1 = subtract) |
| bandLoad | input | 1 | Pulse: load the band starting frequency |
| bandCode | input | BAND_W | Band selector code |
| chanSel | input | CH_W | Channel slot index |
| savePulse | input | 1 | Pulse: store the settings to the slot |
| recallPulse | input | 1 | Pulse: restore the settings from the slot |
| dispFreq | output | 32 | Main (displayed) frequency in Hz |
| ritOut | output | 32 | Clarifier value in Hz, two's complement |
| freqOut | output | 32 | Composed output frequency in Hz |
| changeStb | output | 1 | One-cycle pulse on each change of `freqOut` |

## Verification
An encoder edge driven just before clock edge k reaches the synchronizer output at edge k+1. It moves `dispFreq`, `ritOut` or the trim at edge k+2, and `freqOut` and `changeStb` at edge k+3. A control pulse sampled at edge k moves the registers at k and the composed output at k+1. After every stimulus the bench waits six falling edges before it compares against its arithmetic model, so each result has settled. It counts `changeStb` on falling edges, where the one-cycle pulse is stable, and compares that count with the number of changes in the modelled output.

// File: rtl/vfo_pkg.sv
package vfo_pkg;

  typedef enum logic [1:0] {
    MODE_MAIN = 2'd0,
    MODE_RIT  = 2'd1,
    MODE_CAL  = 2'd2,
    MODE_HOLD = 2'd3
  } tune_mode_t;

  // strobes from control to datapath, at most one target per cycle
  typedef struct packed {
    logic mainUp;
    logic mainDn;
    logic ritUp;
    logic ritDn;
    logic calUp;
    logic calDn;
    logic bandLoad;
    logic save;
    logic recall;
  } tune_strobe_t;

endpackage

// File: rtl/quad_step_decoder.sv
module quad_step_decoder (
  input  logic clk,
  input  logic rstN,
  input  logic encA,
  input  logic encB,
  output logic stepUp,
  output logic stepDn
);
  logic [1:0] syncQ1, syncQ2, lastAb;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ1 <= 2'b00;
      syncQ2 <= 2'b00;
      lastAb <= 2'b00;
    end else begin
      syncQ1 <= {encA, encB};
      syncQ2 <= syncQ1;
      lastAb <= syncQ2;
    end
  end

  // forward order (A leads): 00 -> 10 -> 11 -> 01 -> 00
  always_comb begin
    stepUp = 1'b0;
    stepDn = 1'b0;
    case ({lastAb, syncQ2})
      4'b00_10, 4'b10_11, 4'b11_01, 4'b01_00: stepUp = 1'b1;
      4'b00_01, 4'b01_11, 4'b11_10, 4'b10_00: stepDn = 1'b1;
      default: ; // no change or a double-bit jump
    endcase
  end
endmodule

// File: rtl/tune_control.sv
module tune_control
  import vfo_pkg::*;
(
  input  logic         stepUp,
  input  logic         stepDn,
  input  tune_mode_t   mode,
  input  logic         bandLoadIn,
  input  logic         saveIn,
  input  logic         recallIn,
  output tune_strobe_t stb
);
  logic stepOk;

  always_comb begin
    stb        = '0;
    stepOk     = !recallIn && !bandLoadIn;
    stb.recall = recallIn;
    stb.save   = saveIn;
    stb.bandLoad = bandLoadIn && !recallIn;
    if (stepOk) begin
      unique case (mode)
        MODE_MAIN: begin stb.mainUp = stepUp; stb.mainDn = stepDn; end
        MODE_RIT:  begin stb.ritUp  = stepUp; stb.ritDn  = stepDn; end
        MODE_CAL:  begin stb.calUp  = stepUp; stb.calDn  = stepDn; end
        MODE_HOLD: ;
      endcase
    end
  end
endmodule

// File: rtl/tune_datapath.sv
module tune_datapath
  import vfo_pkg::*;
#(
  parameter logic [31:0] F_MIN     = 32'd100_000,
  parameter logic [31:0] F_MAX     = 32'd30_000_000,
  parameter logic [31:0] BAND_BASE = 32'd1_800_000,
  parameter logic [31:0] BAND_STEP = 32'd1_000_000,
  parameter logic [31:0] OFF0_HZ   = 32'd455_000,
  parameter logic [31:0] OFF1_HZ   = 32'd700,
  parameter int          RIT_LIM   = 10000,
  parameter int          CAL_LIM   = 1000,
  parameter int          NUM_CH    = 16,
  parameter int          BAND_W    = 4,
  localparam int         CH_W      = $clog2(NUM_CH),
  localparam int         NUM_OFF   = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  tune_strobe_t       stb,
  input  logic [BAND_W-1:0]  bandCode,
  input  logic [CH_W-1:0]    chanSel,
  input  logic               ritEn,
  input  logic [NUM_OFF-1:0] offEn,
  input  logic [NUM_OFF-1:0] offNeg,
  output logic [31:0]        mainFreq,
  output logic [31:0]        ritVal,
  output logic [31:0]        freqOut,
  output logic               changeStb
);
  localparam logic [31:0] MAIN_STEP = 32'd10;
  localparam int          RIT_STEP  = 10;
  localparam logic [NUM_OFF-1:0][31:0] OFF_TAB = {OFF1_HZ, OFF0_HZ};

  logic [31:0] calVal;
  logic [31:0] mainNext, ritNext, calNext, sumNext;
  logic [31:0] memMain [NUM_CH];
  logic [31:0] memRit  [NUM_CH];
  logic [31:0] offTerm [NUM_OFF];

  function automatic logic [31:0] clampMain(input logic [32:0] v);
    if (v > {1'b0, F_MAX}) return F_MAX;
    if (v < {1'b0, F_MIN}) return F_MIN;
    return v[31:0];
  endfunction

  function automatic logic [31:0] stepSigned(input logic [31:0] cur, input int step,
                                             input int lim, input logic up);
    int s;
    s = int'($signed(cur));
    if (up) return (s >= lim - step) ? 32'(lim)  : 32'(s + step);
    else    return (s <= step - lim) ? 32'(-lim) : 32'(s - step);
  endfunction

  always_comb begin
    mainNext = mainFreq;
    if (stb.recall)
      mainNext = memMain[chanSel];
    else if (stb.bandLoad)
      mainNext = clampMain({1'b0, BAND_BASE} + 33'(bandCode) * 33'(BAND_STEP));
    else if (stb.mainUp)
      mainNext = clampMain({1'b0, mainFreq} + {1'b0, MAIN_STEP});
    else if (stb.mainDn)
      mainNext = (mainFreq < F_MIN + MAIN_STEP) ? F_MIN : mainFreq - MAIN_STEP;
  end

  always_comb begin
    ritNext = ritVal;
    if (stb.recall)     ritNext = memRit[chanSel];
    else if (stb.ritUp) ritNext = stepSigned(ritVal, RIT_STEP, RIT_LIM, 1'b1);
    else if (stb.ritDn) ritNext = stepSigned(ritVal, RIT_STEP, RIT_LIM, 1'b0);
  end

  always_comb begin
    calNext = calVal;
    if (stb.calUp)      calNext = stepSigned(calVal, 1, CAL_LIM, 1'b1);
    else if (stb.calDn) calNext = stepSigned(calVal, 1, CAL_LIM, 1'b0);
  end

  for (genvar g = 0; g < NUM_OFF; g++) begin : gOff
    assign offTerm[g] = !offEn[g] ? 32'd0 :
                        (offNeg[g] ? (32'd0 - OFF_TAB[g]) : OFF_TAB[g]);
  end

  always_comb begin
    sumNext = mainFreq + (ritEn ? ritVal : 32'd0) + calVal;
    for (int k = 0; k < NUM_OFF; k++) sumNext = sumNext + offTerm[k];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mainFreq  <= BAND_BASE;
      ritVal    <= '0;
      calVal    <= '0;
      freqOut   <= BAND_BASE;
      changeStb <= 1'b0;
      for (int i = 0; i < NUM_CH; i++) begin
        memMain[i] <= BAND_BASE;
        memRit[i]  <= '0;
      end
    end else begin
      mainFreq  <= mainNext;
      ritVal    <= ritNext;
      calVal    <= calNext;
      freqOut   <= sumNext;
      changeStb <= (sumNext != freqOut);
      if (stb.save) begin
        memMain[chanSel] <= mainFreq;
        memRit[chanSel]  <= ritVal;
      end
    end
  end
endmodule

// File: rtl/vfo_tune_ctrl.sv
module vfo_tune_ctrl
  import vfo_pkg::*;
#(
  parameter logic [31:0] F_MIN     = 32'd100_000,
  parameter logic [31:0] F_MAX     = 32'd30_000_000,
  parameter logic [31:0] BAND_BASE = 32'd1_800_000,
  parameter logic [31:0] BAND_STEP = 32'd1_000_000,
  parameter logic [31:0] OFF0_HZ   = 32'd455_000,
  parameter logic [31:0] OFF1_HZ   = 32'd700,
  parameter int          RIT_LIM   = 10000,
  parameter int          CAL_LIM   = 1000,
  parameter int          NUM_CH    = 16,
  parameter int          BAND_W    = 4,
  localparam int         CH_W      = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              encA,
  input  logic              encB,
  input  logic [1:0]        modeSel,
  input  logic              ritEn,
  input  logic [1:0]        offEn,
  input  logic [1:0]        offNeg,
  input  logic              bandLoad,
  input  logic [BAND_W-1:0] bandCode,
  input  logic [CH_W-1:0]   chanSel,
  input  logic              savePulse,
  input  logic              recallPulse,
  output logic [31:0]       dispFreq,
  output logic [31:0]       ritOut,
  output logic [31:0]       freqOut,
  output logic              changeStb
);
  logic         stepUp, stepDn;
  tune_strobe_t stb;

  quad_step_decoder uDec (
    .clk(clk), .rstN(rstN), .encA(encA), .encB(encB),
    .stepUp(stepUp), .stepDn(stepDn)
  );

  tune_control uCtl (
    .stepUp(stepUp), .stepDn(stepDn), .mode(tune_mode_t'(modeSel)),
    .bandLoadIn(bandLoad), .saveIn(savePulse), .recallIn(recallPulse),
    .stb(stb)
  );

  tune_datapath #(
    .F_MIN(F_MIN), .F_MAX(F_MAX), .BAND_BASE(BAND_BASE), .BAND_STEP(BAND_STEP),
    .OFF0_HZ(OFF0_HZ), .OFF1_HZ(OFF1_HZ), .RIT_LIM(RIT_LIM), .CAL_LIM(CAL_LIM),
    .NUM_CH(NUM_CH), .BAND_W(BAND_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .bandCode(bandCode), .chanSel(chanSel),
    .ritEn(ritEn), .offEn(offEn), .offNeg(offNeg),
    .mainFreq(dispFreq), .ritVal(ritOut), .freqOut(freqOut), .changeStb(changeStb)
  );
endmodule

// File: rtl/vfo_tune_checker.sv
module vfo_tune_checker #(
  parameter logic [31:0] F_MIN   = 32'd100_000,
  parameter logic [31:0] F_MAX   = 32'd30_000_000,
  parameter int          RIT_LIM = 10000
) (
  input logic        clk,
  input logic        rstN,
  input logic [1:0]  modeSel,
  input logic        bandLoad,
  input logic        recallPulse,
  input logic [31:0] dispFreq,
  input logic [31:0] ritOut,
  input logic [31:0] freqOut,
  input logic        changeStb
);
  assert_main_range_R4: assert property (@(posedge clk) disable iff (!rstN)
    (dispFreq >= F_MIN) && (dispFreq <= F_MAX));

  assert_rit_bound_R5: assert property (@(posedge clk) disable iff (!rstN)
    ($signed(ritOut) <= RIT_LIM) && ($signed(ritOut) >= -RIT_LIM));

  assert_rit_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ritOut != $past(ritOut)) |->
      ($past(recallPulse) || ((ritOut - $past(ritOut)) == 32'd10) ||
       (($past(ritOut) - ritOut) == 32'd10)));

  assert_cal_freeze_R6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(modeSel) == 2'd2 && !$past(recallPulse) && !$past(bandLoad))
      |-> (dispFreq == $past(dispFreq)));

  assert_stb_on_change_R10: assert property (@(posedge clk) disable iff (!rstN)
    (freqOut != $past(freqOut)) |-> changeStb);

  assert_stb_only_change_R10: assert property (@(posedge clk) disable iff (!rstN)
    changeStb |-> (freqOut != $past(freqOut)));
endmodule

bind vfo_tune_ctrl vfo_tune_checker #(
  .F_MIN(F_MIN), .F_MAX(F_MAX), .RIT_LIM(RIT_LIM)
) uChk (
  .clk(clk), .rstN(rstN), .modeSel(modeSel), .bandLoad(bandLoad),
  .recallPulse(recallPulse), .dispFreq(dispFreq), .ritOut(ritOut),
  .freqOut(freqOut), .changeStb(changeStb)
);

// File: tb/sim_vfo_tune_ctrl.sv
module sim_vfo_tune_ctrl;
  localparam logic [31:0] FMIN  = 32'd1_000_000;
  localparam logic [31:0] FMAX  = 32'd1_000_200;
  localparam logic [31:0] BASE  = 32'd1_000_100;
  localparam logic [31:0] BSTEP = 32'd20;
  localparam logic [31:0] OFF0  = 32'd455_000;
  localparam logic [31:0] OFF1  = 32'd700;
  localparam int          RLIM  = 10000;
  localparam int          CLIM  = 20;

  logic clk = 0, rstN = 0, encA = 0, encB = 0, ritEn = 0;
  logic [1:0] modeSel = 0, offEn = 0, offNeg = 0;
  logic bandLoad = 0, savePulse = 0, recallPulse = 0;
  logic [3:0] bandCode = 0, chanSel = 0;
  logic [31:0] dispFreq, ritOut, freqOut;
  logic changeStb;

  int nChecks = 0, nFails = 0, stbSeen = 0, stbExp = 0;
  int mMain, mRit = 0, mCal = 0;
  int memM [16];
  int memR [16];
  logic [31:0] lastExp;

  always #2 clk = ~clk;

  vfo_tune_ctrl #(
    .F_MIN(FMIN), .F_MAX(FMAX), .BAND_BASE(BASE), .BAND_STEP(BSTEP),
    .OFF0_HZ(OFF0), .OFF1_HZ(OFF1), .RIT_LIM(RLIM), .CAL_LIM(CLIM)
  ) u0 (.*);

  always @(negedge clk) if (rstN && changeStb) stbSeen++;

  function automatic logic [31:0] expOut();
    int s;
    s = mMain + (ritEn ? mRit : 0) + mCal;
    if (offEn[0]) s = offNeg[0] ? s - int'(OFF0) : s + int'(OFF0);
    if (offEn[1]) s = offNeg[1] ? s - int'(OFF1) : s + int'(OFF1);
    return 32'(s);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, $signed(act), $signed(exp));
    end
  endtask

  task automatic settle();
    logic [31:0] e;
    repeat (6) @(negedge clk);
    e = expOut();
    if (e != lastExp) stbExp++;
    lastExp = e;
  endtask

  task automatic checkAll(input string req);
    chk({req, " dispFreq"}, dispFreq, 32'(mMain));
    chk({req, " ritOut"}, ritOut, 32'(mRit));
    chk({req, " freqOut"}, freqOut, expOut());
  endtask

  function automatic int clampI(input int v, input int lo, input int hi);
    return v > hi ? hi : (v < lo ? lo : v);
  endfunction

  // one quadrature transition; forward order AB 00->10->11->01->00
  task automatic encStep(input bit up);
    logic [1:0] ab, nx;
    ab = {encA, encB};
    if (up) nx = (ab == 2'b00) ? 2'b10 : (ab == 2'b10) ? 2'b11 : (ab == 2'b11) ? 2'b01 : 2'b00;
    else    nx = (ab == 2'b00) ? 2'b01 : (ab == 2'b01) ? 2'b11 : (ab == 2'b11) ? 2'b10 : 2'b00;
    @(negedge clk) {encA, encB} = nx;
    case (modeSel)
      2'd0: mMain = clampI(mMain + (up ? 10 : -10), int'(FMIN), int'(FMAX));
      2'd1: mRit  = clampI(mRit + (up ? 10 : -10), -RLIM, RLIM);
      2'd2: mCal  = clampI(mCal + (up ? 1 : -1), -CLIM, CLIM);
      default: ;
    endcase
    settle();
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk) sig = 1'b1;
    @(negedge clk) sig = 1'b0;
    settle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    mMain = int'(BASE);
    for (int i = 0; i < 16; i++) begin memM[i] = int'(BASE); memR[i] = 0; end
    repeat (4) @(negedge clk);
    chk("R1 reset freqOut", freqOut, BASE);
    chk("R1 reset changeStb", 32'(changeStb), 0);
    rstN = 1;
    lastExp = BASE;
    repeat (4) @(negedge clk);
    checkAll("R1 after reset");
    chk("R1 no strobe", 32'(stbSeen), 0);

    // main tuning, R2 and saturation R4
    for (int i = 0; i < 15; i++) begin encStep(1); checkAll("R2/R4 main up"); end
    for (int i = 0; i < 25; i++) begin encStep(0); checkAll("R2/R4 main down"); end
    for (int i = 0; i < 7; i++)  begin encStep(1); checkAll("R2 main up again"); end

    // illegal double-bit jumps, R3
    for (int i = 0; i < 4; i++) begin
      @(negedge clk) {encA, encB} = ~{encA, encB};
      settle();
      checkAll("R3 double jump ignored");
    end

    // hold mode, R2
    modeSel = 2'd3;
    for (int i = 0; i < 6; i++) begin encStep(i[0]); checkAll("R2 hold ignored"); end

    // clarifier, R5
    modeSel = 2'd1; ritEn = 1;
    for (int i = 0; i < 1005; i++) begin encStep(1); checkAll("R5 rit up"); end
    for (int i = 0; i < 2006; i++) begin encStep(0); checkAll("R5 rit down"); end
    for (int i = 0; i < 1007; i++) encStep(1);
    checkAll("R5 rit mid");
    ritEn = 0; settle(); checkAll("R5 rit disabled");
    ritEn = 1; settle(); checkAll("R5 rit enabled");

    // calibration, R6
    modeSel = 2'd2;
    for (int i = 0; i < 25; i++) begin encStep(1); checkAll("R6 cal up"); end
    for (int i = 0; i < 45; i++) begin encStep(0); checkAll("R6 cal down"); end
    for (int i = 0; i < 27; i++) encStep(1);
    checkAll("R6 cal back");

    // offsets, R7
    for (int c = 0; c < 16; c++) begin
      offEn = c[1:0]; offNeg = c[3:2];
      settle();
      checkAll("R7 offsets");
    end
    offEn = 0; offNeg = 0; settle();

    // band load, R8
    modeSel = 2'd0;
    for (int b = 0; b < 16; b++) begin
      bandCode = 4'(b);
      mMain = clampI(int'(BASE) + b * int'(BSTEP), int'(FMIN), int'(FMAX));
      pulse(bandLoad);
      checkAll("R8 band load");
    end

    // channel slots, R9
    for (int ch = 0; ch < 16; ch++) begin
      modeSel = 2'd0;
      bandCode = 4'(ch % 6);
      mMain = clampI(int'(BASE) + (ch % 6) * int'(BSTEP), int'(FMIN), int'(FMAX));
      pulse(bandLoad);
      encStep(0);
      modeSel = 2'd1;
      for (int k = 0; k < ch; k++) encStep(ch[0]);
      chanSel = 4'(ch);
      memM[ch] = mMain; memR[ch] = mRit;
      pulse(savePulse);
      checkAll("R9 save no change");
    end
    modeSel = 2'd0;
    for (int i = 0; i < 3; i++) encStep(0);
    for (int ch = 15; ch >= 0; ch--) begin
      chanSel = 4'(ch);
      mMain = memM[ch]; mRit = memR[ch];
      pulse(recallPulse);
      checkAll("R9 recall");
    end
    // recall wins over band load in the same cycle
    chanSel = 4'd3; bandCode = 4'd9;
    @(negedge clk) begin recallPulse = 1; bandLoad = 1; end
    @(negedge clk) begin recallPulse = 0; bandLoad = 0; end
    mMain = memM[3]; mRit = memR[3];
    settle();
    checkAll("R9 recall priority");

    // composed change strobe count, R10
    chk("R10 strobe count", 32'(stbSeen), 32'(stbExp));

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule